// File: doc/BRIEF.md
# Streaming Accelerator Shell with Host Register Bank

This block sits between a host bus and a swappable streaming processing chain. The host first fills an input buffer through a memory window. It then writes the length of the block and any chain parameters, and sets a start bit. The shell streams the buffered words into the chain's first stage. It collects the chain's results into an output buffer, and the host reads them back once a sticky completion flag appears in the status register.

The chain's parameters, for example a scaling gain, are plain registers driven straight onto an output port. Changing a parameter alters the chain's behaviour on the next cycle, with no restart and no change of logic. The chain reports events by pushing a code into a sensing register, which the host polls. A block longer than the buffers is handled by the host through repeated fill/start/complete rounds on the same shell, with no reset in between.

Both stream interfaces use valid/ready. On the source side, once `src_valid` is high, `src_data` stays unchanged until `src_ready` accepts it. On the sink side, the chain must hold `sink_data` while `sink_valid` is high and `sink_ready` is low. The shell lowers `sink_ready` whenever it is not collecting a block.

Top module: `accel_shell`

## Requirements
- R1: After reset, the status register reads 0, the gain register reads 1, the length and sensing registers read 0, the `gain` port is 1, and both `src_valid` and `sink_ready` are low.
- R2: Byte addresses are decoded by their two top bits: 00 selects registers, 01 the input buffer and 10 the output buffer, with the word index taken from address bits [9:2]. The registers are control 0x000, status 0x004, length 0x008, gain 0x00C and sensing 0x010. A read request returns its data with `bus_rvalid` on the following cycle.
- R3: Reads return zero for window 11, for register offsets above 0x010 and for addresses that are not word-aligned. Host writes to the sensing register, to the output buffer and to status bit 0 change nothing.
- R4: Writing 1 to control bit 0 while idle makes status bit 0 (busy) read 1 from the next cycle on. The control register always reads 0.
- R5: While busy, input-buffer words 0 to length-1 are offered in order on the source stream, and each offer is held stable until it is accepted.
- R6: Each word accepted on the sink stream is stored at the next output-buffer index, starting at 0. `sink_ready` is high only while busy.
- R7: Busy stays high until the last of the length output words is accepted. In that same cycle status bit 1 (done) is set, and it stays set until the host writes 1 to status bit 1.
- R8: A start written while busy is ignored: no second block runs after the current one ends.
- R9: A write to the gain register appears on the `gain` port on the next cycle, with no restart.
- R10: When `event_valid` is high, `event_code` is captured into the sensing register, and the host reads it there.
- R11: A length write above 256 stores 256. A start with length 0 sets done at once and never raises busy.
- R12: Consecutive blocks run back to back without a reset, and each one starts again from buffer index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| src_valid | output | 1 | Source stream word offered to chain |
| src_ready | input | 1 | Chain accepts the source word |
| src_data | output | 32 | Source stream word |
| sink_valid | input | 1 | Chain offers a result word |
| sink_ready | output | 1 | Shell accepts the result word |
| sink_data | input | 32 | Result word from chain |
| gain | output | 32 | Live gain parameter for the chain |
| event_valid | input | 1 | Chain posts an event code |
| event_code | input | 32 | Event code for the sensing register |

## Verification
On every cycle the assertions check the following: the one-cycle read return, zero data from the unmapped window, that a stalled source word holds stable, that both streams are gated by busy, that busy falls only on an accepted sink word with done raised at once, and that gain and event codes land one cycle after they are written. Only the bench's scenarios can show the rest. These are the exact output contents for several lengths, gains and stall patterns, the clamp on length and the zero-length case, the rejection of a start written mid-block, and the read-only behaviour of the sensing register and the output buffer.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    WIN_REG  = 2'd0,
    WIN_IN   = 2'd1,
    WIN_OUT  = 2'd2,
    WIN_NONE = 2'd3
  } acc_win_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned REG_LEN   = 2;
  localparam int unsigned REG_GAIN  = 3;
  localparam int unsigned REG_SENSE = 4;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;

endpackage

// File: rtl/acc_buf.sv
module acc_buf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int NRD   = 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [IDX_W-1:0]               waddr,
  input  logic [WIDTH-1:0]               wdata,
  input  logic [NRD-1:0][IDX_W-1:0]      rd_addr,
  output logic [NRD-1:0][WIDTH-1:0]      rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 32,
  parameter int GAIN_RST = 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              finish,
  input  logic              event_valid,
  input  logic [DATA_W-1:0] event_code,
  output logic              start,
  output logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] gain,
  output logic              done,
  output logic [DATA_W-1:0] sense
);

  logic wr_ctrl, wr_stat, wr_len, wr_gain;

  assign wr_ctrl = wr_en && (wr_idx == IDX_W'(REG_CTRL));
  assign wr_stat = wr_en && (wr_idx == IDX_W'(REG_STAT));
  assign wr_len  = wr_en && (wr_idx == IDX_W'(REG_LEN));
  assign wr_gain = wr_en && (wr_idx == IDX_W'(REG_GAIN));

  // start is a pulse only; it is dropped while a block is running
  assign start = wr_ctrl && wr_data[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len   <= '0;
      gain  <= DATA_W'(GAIN_RST);
      done  <= 1'b0;
      sense <= '0;
    end else begin
      if (wr_len) begin
        if (wr_data > DATA_W'(DEPTH)) len <= LEN_W'(DEPTH);
        else                          len <= wr_data[LEN_W-1:0];
      end
      if (wr_gain) gain <= wr_data;
      if (finish)
        done <= 1'b1;
      else if (wr_stat && wr_data[STAT_DONE_BIT])
        done <= 1'b0;
      if (event_valid) sense <= event_code;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_W'(REG_STAT): begin
        rd_data[STAT_BUSY_BIT] = busy;
        rd_data[STAT_DONE_BIT] = done;
      end
      IDX_W'(REG_LEN):   rd_data[LEN_W-1:0] = len;
      IDX_W'(REG_GAIN):  rd_data = gain;
      IDX_W'(REG_SENSE): rd_data = sense;
      default:           rd_data = '0;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             finish,
  output logic             src_valid,
  input  logic             src_ready,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             sink_valid,
  output logic             sink_ready,
  output logic             out_we,
  output logic [IDX_W-1:0] out_idx
);

  logic [LEN_W-1:0] rp, wp;
  logic src_hs, sink_hs, last_hs;

  assign src_valid  = busy && (rp < len);
  assign sink_ready = busy && (wp < len);
  assign src_hs     = src_valid && src_ready;
  assign sink_hs    = sink_valid && sink_ready;
  assign last_hs    = sink_hs && (wp == len - LEN_W'(1));
  assign finish     = (start && (len == '0)) || last_hs;

  assign rd_idx  = rp[IDX_W-1:0];
  assign out_idx = wp[IDX_W-1:0];
  assign out_we  = sink_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rp   <= '0;
      wp   <= '0;
    end else if (start && (len != '0)) begin
      busy <= 1'b1;
      rp   <= '0;
      wp   <= '0;
    end else begin
      if (src_hs)  rp <= rp + LEN_W'(1);
      if (sink_hs) wp <= wp + LEN_W'(1);
      if (last_hs) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/accel_shell.sv
module accel_shell
  import acc_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 32,
  parameter int GAIN_RST = 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = IDX_W + 1,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              src_valid,
  input  logic              src_ready,
  output logic [DATA_W-1:0] src_data,
  input  logic              sink_valid,
  output logic              sink_ready,
  input  logic [DATA_W-1:0] sink_data,
  output logic [DATA_W-1:0] gain,
  input  logic              event_valid,
  input  logic [DATA_W-1:0] event_code
);

  acc_win_e         win;
  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             host_wr, host_rd;

  assign win     = acc_win_e'(bus_addr[ADDR_W-1 -: 2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = bus_addr[IDX_W+1:2];
  assign host_wr = bus_sel && bus_wr && aligned;
  assign host_rd = bus_sel && !bus_wr;

  logic              busy_w, done_w, start_w, finish_w;
  logic [LEN_W-1:0]  len_w;
  logic [DATA_W-1:0] reg_rd, sense_w;
  logic [IDX_W-1:0]  seq_rd_idx, seq_out_idx;
  logic              seq_out_we;

  acc_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .GAIN_RST(GAIN_RST)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr && (win == WIN_REG)), .wr_idx(idx), .wr_data(bus_wdata),
    .rd_idx(idx), .rd_data(reg_rd),
    .busy(busy_w), .finish(finish_w),
    .event_valid(event_valid), .event_code(event_code),
    .start(start_w), .len(len_w), .gain(gain), .done(done_w), .sense(sense_w)
  );

  acc_seq #(.DEPTH(DEPTH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start_w), .len(len_w),
    .busy(busy_w), .finish(finish_w),
    .src_valid(src_valid), .src_ready(src_ready), .rd_idx(seq_rd_idx),
    .sink_valid(sink_valid), .sink_ready(sink_ready),
    .out_we(seq_out_we), .out_idx(seq_out_idx)
  );

  logic [1:0][IDX_W-1:0]  in_raddr;
  logic [1:0][DATA_W-1:0] in_rdata;
  logic [0:0][IDX_W-1:0]  out_raddr;
  logic [0:0][DATA_W-1:0] out_rdata;

  assign in_raddr[0] = seq_rd_idx;
  assign in_raddr[1] = idx;
  assign out_raddr[0] = idx;
  assign src_data = in_rdata[0];

  acc_buf #(.DEPTH(DEPTH), .WIDTH(DATA_W), .NRD(2)) in_buf_i (
    .clk(clk), .we(host_wr && (win == WIN_IN)), .waddr(idx), .wdata(bus_wdata),
    .rd_addr(in_raddr), .rd_data(in_rdata)
  );

  acc_buf #(.DEPTH(DEPTH), .WIDTH(DATA_W), .NRD(1)) out_buf_i (
    .clk(clk), .we(seq_out_we), .waddr(seq_out_idx), .wdata(sink_data),
    .rd_addr(out_raddr), .rd_data(out_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= host_rd;
      if (host_rd && aligned) begin
        case (win)
          WIN_REG: bus_rdata <= reg_rd;
          WIN_IN:  bus_rdata <= in_rdata[1];
          WIN_OUT: bus_rdata <= out_rdata[0];
          default: bus_rdata <= '0;
        endcase
      end else begin
        bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/accel_shell_chk.sv
module accel_shell_chk #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              src_valid,
  input logic              src_ready,
  input logic [DATA_W-1:0] src_data,
  input logic              sink_valid,
  input logic              sink_ready,
  input logic [DATA_W-1:0] gain,
  input logic              event_valid,
  input logic [DATA_W-1:0] event_code,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] sense
);

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr[ADDR_W-1 -: 2] == 2'b11)) |=> (bus_rdata == '0));

  assert_src_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data)));

  assert_src_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> busy);

  assert_sink_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sink_ready |-> busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && $past(sink_valid && sink_ready)));

  assert_gain_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == ADDR_W'(12))) |=> (gain == $past(bus_wdata)));

  assert_sense_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    event_valid |=> (sense == $past(event_code)));

endmodule

bind accel_shell accel_shell_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .src_valid(src_valid), .src_ready(src_ready),
  .src_data(src_data), .sink_valid(sink_valid), .sink_ready(sink_ready),
  .gain(gain), .event_valid(event_valid), .event_code(event_code),
  .busy(busy_w), .done(done_w), .sense(sense_w)
);

// File: tb/accel_shell_tb_top.sv
module accel_shell_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int DW    = 32;
  localparam int AW    = 12;

  localparam logic [AW-1:0] A_CTRL  = 12'h000;
  localparam logic [AW-1:0] A_STAT  = 12'h004;
  localparam logic [AW-1:0] A_LEN   = 12'h008;
  localparam logic [AW-1:0] A_GAIN  = 12'h00C;
  localparam logic [AW-1:0] A_SENSE = 12'h010;
  localparam int IN_BASE  = 'h400;
  localparam int OUT_BASE = 'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_rvalid;
  logic src_valid, src_ready, sink_valid, sink_ready;
  logic [DW-1:0] src_data, sink_data, gain_o;
  logic event_valid = 1'b0;
  logic [DW-1:0] event_code = '0;
  logic stall_en = 1'b0;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_shell #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .sink_valid(sink_valid), .sink_ready(sink_ready),
    .sink_data(sink_data), .gain(gain_o), .event_valid(event_valid),
    .event_code(event_code)
  );

  // chain model: one-stage scaling by the live gain, with optional stalls
  logic [3:0] cyc;
  logic hv;
  logic [DW-1:0] hdata;
  logic stall;
  assign stall      = stall_en && (cyc[1:0] != 2'b00);
  assign src_ready  = (!hv || sink_ready) && !stall;
  assign sink_valid = hv;
  assign sink_data  = hdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0; hv <= 1'b0; hdata <= '0;
    end else begin
      cyc <= cyc + 4'd1;
      if (src_valid && src_ready) begin
        hv <= 1'b1; hdata <= src_data * gain_o;
      end else if (sink_ready) begin
        hv <= 1'b0;
      end
    end
  end

  typedef struct packed {
    logic [31:0] len;
    logic [31:0] gain;
    logic [31:0] seed;
    logic [31:0] step;
    logic [31:0] stall;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'd8,   32'd3,          32'd5,          32'd11,    32'd0},
    '{32'd1,   32'hFFFF_FFFF,  32'h0000_1234,  32'd0,     32'd1},
    '{32'd256, 32'd2,          32'h0000_0100,  32'd3,     32'd1},
    '{32'd17,  32'h0001_0001,  32'hFFFF_0000,  32'h777,   32'd0}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [DW-1:0] s;
    for (int k = 0; k < 3000; k++) begin
      bus_read(A_STAT, s);
      if (s[1]) break;
    end
  endtask

  task automatic post_event(input logic [DW-1:0] code);
    @(negedge clk);
    event_valid = 1'b1; event_code = code;
    @(posedge clk);
    @(negedge clk);
    event_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog R7 actual=no completion expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] exp;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 src_valid", {31'd0, src_valid}, 32'd0);
    chk("R1 sink_ready", {31'd0, sink_ready}, 32'd0);
    chk("R1 gain port", gain_o, 32'd1);
    bus_read(A_STAT, rd);  chk("R1 status", rd, 32'd0);
    chk("R2 rvalid", {31'd0, bus_rvalid}, 32'd1);
    bus_read(A_GAIN, rd);  chk("R1 gain reg", rd, 32'd1);
    bus_read(A_LEN, rd);   chk("R1 length", rd, 32'd0);
    bus_read(A_SENSE, rd); chk("R1 sense", rd, 32'd0);

    // table walk: R2 R5 R6 R7 R9 R12
    for (int v = 0; v < 4; v++) begin
      stall_en = VECS[v].stall[0];
      bus_write(A_LEN, VECS[v].len);
      bus_write(A_GAIN, VECS[v].gain);
      chk("R9 gain port", gain_o, VECS[v].gain);
      for (int i = 0; i < int'(VECS[v].len); i++)
        bus_write(AW'(IN_BASE + 4*i), VECS[v].seed + VECS[v].step * i);
      bus_read(AW'(IN_BASE), rd);
      chk("R2 input window", rd, VECS[v].seed);
      bus_write(A_CTRL, 32'd1);
      bus_read(A_STAT, rd);
      chk("R4 busy after start", {31'd0, rd[0]}, 32'd1);
      wait_done();
      bus_read(A_STAT, rd);
      chk("R7 done and idle", rd, 32'd2);
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        bus_read(AW'(OUT_BASE + 4*i), rd);
        exp = (VECS[v].seed + VECS[v].step * i) * VECS[v].gain;
        chk((v == 0) ? "R5 R6 output word" : "R6 R12 output word", rd, exp);
      end
      bus_write(A_STAT, 32'd2);
      bus_read(A_STAT, rd);
      chk("R7 done cleared", rd, 32'd0);
    end

    // start while busy: R4 R8
    stall_en = 1'b1;
    bus_write(A_LEN, 32'd64);
    bus_write(A_GAIN, 32'd5);
    for (int i = 0; i < 64; i++) bus_write(AW'(IN_BASE + 4*i), 32'(i + 1));
    bus_write(A_CTRL, 32'd1);
    bus_read(A_CTRL, rd);
    chk("R4 control reads zero", rd, 32'd0);
    bus_write(A_CTRL, 32'd1);
    wait_done();
    repeat (12) @(posedge clk);
    bus_read(A_STAT, rd);
    chk("R8 no second run", rd, 32'd2);
    bus_read(AW'(OUT_BASE + 4*63), rd);
    chk("R8 last word", rd, 32'd320);
    bus_write(A_STAT, 32'd2);
    stall_en = 1'b0;

    // read-only and unmapped: R3
    bus_read(12'h014, rd); chk("R3 unused register", rd, 32'd0);
    bus_read(12'hC00, rd); chk("R3 unmapped window", rd, 32'd0);
    bus_read(12'h00E, rd); chk("R3 misaligned read", rd, 32'd0);
    bus_write(AW'(OUT_BASE), 32'hDEAD_BEEF);
    bus_read(AW'(OUT_BASE), rd); chk("R3 output buffer read-only", rd, 32'd5);
    bus_write(A_STAT, 32'd1);
    bus_read(A_STAT, rd); chk("R3 busy bit read-only", rd, 32'd0);

    // sensing: R10 R3
    post_event(32'h0000_ABCD);
    bus_read(A_SENSE, rd); chk("R10 sense latched", rd, 32'h0000_ABCD);
    bus_write(A_SENSE, 32'h1111_2222);
    bus_read(A_SENSE, rd); chk("R3 sense read-only", rd, 32'h0000_ABCD);
    post_event(32'h0000_0001);
    bus_read(A_SENSE, rd); chk("R10 sense overwritten", rd, 32'h0000_0001);

    // length clamp and zero length: R11
    bus_write(A_LEN, 32'd1000);
    bus_read(A_LEN, rd); chk("R11 length clamp", rd, 32'd256);
    bus_write(A_LEN, 32'd0);
    bus_write(A_CTRL, 32'd1);
    chk("R11 no source offer", {31'd0, src_valid}, 32'd0);
    bus_read(A_STAT, rd); chk("R11 zero length done", rd, 32'd2);

    // live gain without restart: R9
    bus_write(A_GAIN, 32'h0000_0042);
    chk("R9 gain live", gain_o, 32'h0000_0042);
    bus_read(A_STAT, rd); chk("R9 no restart", rd, 32'd2);

    finish_run();
  end

endmodule